// File: doc/BRIEF.md
# Serial Status and OUT-Data Readout Port

This block is the read side of a slow synchronous serial link through which a microcontroller collects OUT data that a USB low-speed bridge has received. The microcontroller owns the link. It holds a select-like line low, sends one or two strobe pulses on a strobe line, and then clocks bits out with a serial clock. The block changes its serial output on each falling edge of that clock, and the microcontroller samples it on each rising edge. Every byte goes out least significant bit first.

One strobe pulse starts the read at the status byte. The count/info byte follows, and then as many OUT FIFO bytes as the count field gives. Two strobe pulses skip the status byte, so the read starts at the count/info byte. The block also holds the fields of the count/info byte: endpoint, data toggle, SETUP flag and byte count. It holds the EP0 OUT-done flag as well. A read that runs to its last bit clears the SETUP flag. If that read started at the status byte, it also clears the OUT-done flag.

Packet decoding and the FIFO storage belong to neighbouring blocks. Here they appear only as a one-cycle packet strobe with its fields, and as a FIFO head byte with a pop pulse. The three link lines are asynchronous to the block clock and are synchronised inside the block.

Top module: `oro_readout_top`

## Requirements
- R1: After reset, and at any time no read is active, `sdo` is 1. After reset the OUT-done flag, the toggle, the SETUP flag, the endpoint and the length are all 0.
- R2: A strobe rising edge while `sin`=0 and no read is active starts a read at the status byte. The read then sends the count/info byte, then the FIFO bytes, each byte least significant bit first. The status byte carries the OUT-done flag in bit 0 and `status_misc[6:0]` in bits 7:1.
- R3: A second strobe rising edge that comes before the first serial-clock falling edge of a read restarts the output at the count/info byte. The read then sends the count/info byte followed by the FIFO bytes, and the status byte is not sent.
- R4: `sdo` changes only after a strobe rising edge, a serial-clock falling edge, or `sin` going high. Each serial-clock falling edge moves the output to the next bit.
- R5: The count/info byte is {endpoint[7:6], toggle[5], SETUP[4], length[3:0]}. A packet length above MAX_LEN (default 8) is stored as MAX_LEN.
- R6: An accepted packet stores its endpoint, its length and its toggle (1 for DATA1, 0 for DATA0). A packet for endpoint 3 is ignored. A SETUP packet for a nonzero endpoint is also ignored.
- R7: An accepted SETUP packet sets the SETUP flag. Any read that completes clears it.
- R8: An accepted EP0 packet sets the OUT-done flag. A completed read that started at the status byte clears it. A completed read that started at the count/info byte leaves it set.
- R9: When both `ep1_en` and `ep2_en` are 0, bits 7:6 of the count/info byte show the REV_ID parameter (default 2'b11) in place of the endpoint.
- R10: A read pulses `fifo_pop` exactly once for each FIFO byte it loads. With a length of 0, the read completes after the count/info byte and pops nothing.
- R11: `sin` going high ends a read early. The block returns to idle with `sdo`=1, and neither flag is cleared.
- R12: When a packet is accepted in the same cycle that a read completes, the set wins: the OUT-done and SETUP flags take the packet's values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the microcontroller (asynchronous) |
| sin | input | 1 | Select line; low enables a read (asynchronous) |
| sdi | input | 1 | Strobe line; each rising edge is one pulse (asynchronous) |
| sdo | output | 1 | Serial data out, least significant bit first |
| status_misc | input | 7 | Status byte bits 7:1 supplied by the neighbouring logic |
| pkt_valid | input | 1 | One-cycle strobe: an OUT or SETUP packet has been received |
| pkt_ep | input | 2 | Endpoint of the packet |
| pkt_data1 | input | 1 | 1 when the packet was DATA1, 0 when it was DATA0 |
| pkt_setup | input | 1 | 1 when the packet followed a SETUP token |
| pkt_len | input | 4 | Number of bytes in the packet |
| ep1_en | input | 1 | EP1 OUT enabled |
| ep2_en | input | 1 | EP2 OUT enabled |
| fifo_data | input | 8 | Head byte of the OUT FIFO |
| fifo_pop | output | 1 | One-cycle pulse: the head byte has been taken |

## Verification
Two events can land in the same clock cycle: a read completing, which clears flags, and a packet being accepted, which sets them. The bench counts the two synchroniser stages. It then raises `pkt_valid` for a SETUP packet on EP0 in exactly the cycle in which the final serial-clock falling edge is acted on. The next status and count/info reads must show OUT-done and SETUP still at 1, along with the new length. The sweeps that surround this test run every length from 0 to 9, every endpoint, both start modes and every enable combination. They check each shifted byte and the number of FIFO pops against a model of the requirements.

// File: rtl/oro_pkg.sv
// Package: shared types for the serial readout port.
// Assumes the count/info byte is 8 bits and the length field is 4 bits.
package oro_pkg;
    localparam int BYTE_W = 8;
    localparam int LEN_W  = 4;

    // Which byte the shift sequencer is currently sending.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_STAT = 2'd1,
        PH_CNT  = 2'd2,
        PH_FIFO = 2'd3
    } phase_e;

    // Stored fields of the count/info byte.
    typedef struct packed {
        logic [1:0]       ep;
        logic             tog;
        logic             setup;
        logic [LEN_W-1:0] len;
    } cnt_fields_t;
endpackage

// File: rtl/oro_sync_edge.sv
// Module: oro_sync_edge
// Synchronises the three asynchronous link lines into clk and gives
// single-cycle events for a serial-clock fall and a strobe rise, plus
// the level of the select line.
// Assumes each line stays at a level for more than STAGES+1 clk cycles.
module oro_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic sin,
    input  logic sdi,
    output logic sck_fall,
    output logic sdi_rise,
    output logic sin_hi
);
    localparam int         NLINES = 3;
    localparam logic [2:0] IDLE_LVL = 3'b011;   // sdi=0, sin=1, sck=1

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] stg [STAGES];
    logic [NLINES-1:0] prev;
    logic [NLINES-1:0] cur;

    assign raw = {sdi, sin, sck};
    assign cur = stg[STAGES-1];

    // First synchroniser stage.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= IDLE_LVL;
        else        stg[0] <= raw;
    end

    // Remaining synchroniser stages.
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= IDLE_LVL;
            else        stg[i] <= stg[i-1];
        end
    end

    // Previous synchronised levels, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= IDLE_LVL;
        else        prev <= cur;
    end

    assign sck_fall = prev[0] & ~cur[0];
    assign sdi_rise = ~prev[2] & cur[2];
    assign sin_hi   = cur[1];
endmodule

// File: rtl/oro_cnt_reg.sv
// Module: oro_cnt_reg
// Holds the count/info fields and the EP0 OUT-done flag. Accepts packet
// strobes from the packet decoder and clears flags when a read completes.
// A set from a packet wins over a clear in the same cycle.
// Assumes pkt_valid lasts one cycle for each packet.
module oro_cnt_reg
    import oro_pkg::*;
#(
    parameter int         MAX_LEN = 8,
    parameter logic [1:0] REV_ID  = 2'b11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [1:0]        pkt_ep,
    input  logic              pkt_data1,
    input  logic              pkt_setup,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic              ep1_en,
    input  logic              ep2_en,
    input  logic              rd_done,
    input  logic              rd_from_stat,
    output logic [BYTE_W-1:0] cnt_byte,
    output logic              out_done
);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);

    cnt_fields_t      f;
    logic             accept;
    logic [LEN_W-1:0] len_clamp;
    logic             any_ep_en;

    // A packet is accepted unless its endpoint is 3, or it is a SETUP packet for a nonzero endpoint.
    assign accept    = pkt_valid && (pkt_ep != 2'd3) && !(pkt_setup && (pkt_ep != 2'd0));
    assign len_clamp = (pkt_len > LEN_MAX) ? LEN_MAX : pkt_len;
    assign any_ep_en = ep1_en | ep2_en;

    // Capture the packet fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f.ep  <= '0;
            f.tog <= 1'b0;
            f.len <= '0;
        end else if (accept) begin
            f.ep  <= pkt_ep;
            f.tog <= pkt_data1;
            f.len <= len_clamp;
        end
    end

    // SETUP flag: a SETUP packet sets it, any completed read clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                     f.setup <= 1'b0;
        else if (accept && pkt_setup)   f.setup <= 1'b1;
        else if (rd_done)               f.setup <= 1'b0;
    end

    // OUT-done flag: an EP0 packet sets it, a completed read from the status byte clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                             out_done <= 1'b0;
        else if (accept && pkt_ep == 2'd0)      out_done <= 1'b1;
        else if (rd_done && rd_from_stat)       out_done <= 1'b0;
    end

    assign cnt_byte = {(any_ep_en ? f.ep : REV_ID), f.tog, f.setup, f.len};

    AST_LEN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        f.len <= LEN_MAX) else $error("stored length above maximum"); // R5
    AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        accept && pkt_ep == 2'd0 |=> out_done) else $error("out-done not set"); // R8
    AST_SETUP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done && !(accept && pkt_setup) |=> !f.setup) else $error("setup not cleared"); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done && accept && pkt_setup |=> f.setup) else $error("clear beat set"); // R12
endmodule

// File: rtl/oro_shift_seq.sv
// Module: oro_shift_seq
// Sequences one read: the status byte (optional), then the count/info byte,
// then the FIFO bytes. Each byte is sent least significant bit first, and
// each serial-clock fall advances one bit. The length is snapshotted when
// the read starts.
// Assumes the events come from oro_sync_edge, one cycle each.
module oro_shift_seq
    import oro_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_fall,
    input  logic              sdi_rise,
    input  logic              sin_hi,
    input  logic [BYTE_W-1:0] status_byte,
    input  logic [BYTE_W-1:0] cnt_byte,
    input  logic [BYTE_W-1:0] fifo_data,
    output logic              sdo,
    output logic              fifo_pop,
    output logic              rd_done,
    output logic              rd_from_stat
);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    phase_e            phase;
    logic [BYTE_W-1:0] shreg;
    logic [BIT_W-1:0]  bitcnt;
    logic [LEN_W-1:0]  snap_len;
    logic [LEN_W-1:0]  rem;
    logic              moved;
    logic              byte_end;
    logic              start_stat;
    logic              start_cnt;
    logic              more_fifo;

    // Decode the events that change the sequence.
    assign byte_end   = sck_fall && !sin_hi && (phase != PH_IDLE) && (bitcnt == LAST_BIT);
    assign start_stat = sdi_rise && !sin_hi && (phase == PH_IDLE);
    assign start_cnt  = sdi_rise && !sin_hi && !sck_fall && (phase == PH_STAT) && !moved;
    assign more_fifo  = ((phase == PH_CNT) && (snap_len != '0)) ||
                        ((phase == PH_FIFO) && (rem != '0));
    assign fifo_pop   = byte_end && more_fifo;
    assign rd_done    = byte_end && !more_fifo && (phase != PH_STAT);

    // Phase, shift register and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase        <= PH_IDLE;
            shreg        <= '0;
            bitcnt       <= '0;
            snap_len     <= '0;
            rem          <= '0;
            moved        <= 1'b0;
            rd_from_stat <= 1'b0;
        end else if (sin_hi) begin
            phase  <= PH_IDLE;
            bitcnt <= '0;
            moved  <= 1'b0;
        end else if (start_stat) begin
            phase        <= PH_STAT;
            shreg        <= status_byte;
            bitcnt       <= '0;
            snap_len     <= cnt_byte[LEN_W-1:0];
            moved        <= 1'b0;
            rd_from_stat <= 1'b1;
        end else if (start_cnt) begin
            phase        <= PH_CNT;
            shreg        <= cnt_byte;
            snap_len     <= cnt_byte[LEN_W-1:0];
            rd_from_stat <= 1'b0;
        end else if (sck_fall && phase != PH_IDLE) begin
            moved <= 1'b1;
            if (!byte_end) begin
                shreg  <= {1'b0, shreg[BYTE_W-1:1]};
                bitcnt <= bitcnt + 1'b1;
            end else begin
                bitcnt <= '0;
                unique case (phase)
                    PH_STAT: begin
                        phase <= PH_CNT;
                        shreg <= cnt_byte;
                    end
                    PH_CNT: begin
                        if (snap_len != '0) begin
                            phase <= PH_FIFO;
                            shreg <= fifo_data;
                            rem   <= snap_len - 1'b1;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                    PH_FIFO: begin
                        if (rem != '0) begin
                            shreg <= fifo_data;
                            rem   <= rem - 1'b1;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    assign sdo = (phase == PH_IDLE) ? 1'b1 : shreg[0];

    AST_SIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sin_hi |=> (phase == PH_IDLE) && sdo) else $error("select high did not idle"); // R11
    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall && !sdi_rise && !sin_hi |=> $stable(sdo)) else $error("sdo moved without event"); // R4
    AST_POP_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (phase == PH_CNT || phase == PH_FIFO)) else $error("pop outside data phase"); // R10
    AST_POP_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fifo_pop, rd_done})) else $error("pop and done together"); // R10
endmodule

// File: rtl/oro_readout_top.sv
// Module: oro_readout_top
// Top of the serial status / OUT-data readout port. It joins the line
// synchroniser, the count/info register and the shift sequencer, and it
// builds the status byte (OUT-done in bit 0).
// Assumes the packet and FIFO signals are synchronous to clk.
module oro_readout_top
    import oro_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         MAX_LEN     = 8,
    parameter logic [1:0] REV_ID      = 2'b11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              sin,
    input  logic              sdi,
    output logic              sdo,
    input  logic [6:0]        status_misc,
    input  logic              pkt_valid,
    input  logic [1:0]        pkt_ep,
    input  logic              pkt_data1,
    input  logic              pkt_setup,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic              ep1_en,
    input  logic              ep2_en,
    input  logic [BYTE_W-1:0] fifo_data,
    output logic              fifo_pop
);
    logic              sck_fall;
    logic              sdi_rise;
    logic              sin_hi;
    logic [BYTE_W-1:0] cnt_byte;
    logic [BYTE_W-1:0] status_byte;
    logic              out_done;
    logic              rd_done;
    logic              rd_from_stat;

    assign status_byte = {status_misc, out_done};

    oro_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .sin      (sin),
        .sdi      (sdi),
        .sck_fall (sck_fall),
        .sdi_rise (sdi_rise),
        .sin_hi   (sin_hi)
    );

    oro_cnt_reg #(.MAX_LEN(MAX_LEN), .REV_ID(REV_ID)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .pkt_valid    (pkt_valid),
        .pkt_ep       (pkt_ep),
        .pkt_data1    (pkt_data1),
        .pkt_setup    (pkt_setup),
        .pkt_len      (pkt_len),
        .ep1_en       (ep1_en),
        .ep2_en       (ep2_en),
        .rd_done      (rd_done),
        .rd_from_stat (rd_from_stat),
        .cnt_byte     (cnt_byte),
        .out_done     (out_done)
    );

    oro_shift_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .sck_fall     (sck_fall),
        .sdi_rise     (sdi_rise),
        .sin_hi       (sin_hi),
        .status_byte  (status_byte),
        .cnt_byte     (cnt_byte),
        .fifo_data    (fifo_data),
        .sdo          (sdo),
        .fifo_pop     (fifo_pop),
        .rd_done      (rd_done),
        .rd_from_stat (rd_from_stat)
    );
endmodule

// File: tb/oro_readout_top_test.sv
// Bench for oro_readout_top: sweeps lengths, endpoints, start modes and
// enable settings against a model of the requirements.
module oro_readout_top_test;
    localparam logic [1:0] REV = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b1, sin = 1'b1, sdi = 1'b0;
    logic       sdo;
    logic [6:0] status_misc = 7'h2D;
    logic       pkt_valid = 1'b0, pkt_data1 = 1'b0, pkt_setup = 1'b0;
    logic [1:0] pkt_ep = 2'd0;
    logic [3:0] pkt_len = 4'd0;
    logic       ep1_en = 1'b0, ep2_en = 1'b0;
    logic [7:0] fifo_data;
    logic       fifo_pop;

    int total = 0;
    int bad = 0;
    int head = 0;
    int seed = 0;
    logic head_clr = 1'b0;
    int cycles = 0;

    // Model state derived from the requirements.
    logic [1:0] m_ep = 2'd0;
    logic       m_tog = 1'b0, m_setup = 1'b0, m_done = 1'b0;
    logic [3:0] m_len = 4'd0;

    always #2.5 clk = ~clk;

    oro_readout_top uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sin(sin), .sdi(sdi), .sdo(sdo),
        .status_misc(status_misc), .pkt_valid(pkt_valid), .pkt_ep(pkt_ep),
        .pkt_data1(pkt_data1), .pkt_setup(pkt_setup), .pkt_len(pkt_len),
        .ep1_en(ep1_en), .ep2_en(ep2_en), .fifo_data(fifo_data), .fifo_pop(fifo_pop)
    );

    // FIFO stand-in: the head byte is a function of the position and of the packet seed.
    assign fifo_data = 8'((head * 37 + seed * 11 + 5) & 255);
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (head_clr)      head <= 0;
        else if (fifo_pop) head <= head + 1;
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cycles > 190000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run did not finish, cycles=%0d expected<190000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string what);
        total = total + 1;
        if (got !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: got=%h expected=%h", what, got, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_cnt();
        return {((ep1_en | ep2_en) ? m_ep : REV), m_tog, m_setup, m_len};
    endfunction

    function automatic logic [7:0] exp_fifo(input int pos);
        return 8'((pos * 37 + seed * 11 + 5) & 255);
    endfunction

    // Drive one packet strobe and update the model (R5, R6, R7, R8).
    task automatic drive_pkt(input logic [1:0] ep, input logic d1, input logic st, input logic [3:0] len);
        pkt_ep = ep; pkt_data1 = d1; pkt_setup = st; pkt_len = len;
        pkt_valid = 1'b1;
        if (ep != 2'd3 && !(st && ep != 2'd0)) begin
            m_ep = ep; m_tog = d1; m_len = (len > 4'd8) ? 4'd8 : len;
            if (st) m_setup = 1'b1;
            if (ep == 2'd0) m_done = 1'b1;
            seed = seed + 1;
            head_clr = 1'b1;
        end
    endtask

    task automatic send_pkt(input logic [1:0] ep, input logic d1, input logic st, input logic [3:0] len);
        @(negedge clk);
        drive_pkt(ep, d1, st, len);
        @(negedge clk);
        pkt_valid = 1'b0; head_clr = 1'b0;
        clks(2);
    endtask

    // One read: np strobe pulses, at most nbytes bytes; when collide is set, a SETUP packet arrives with the last fall.
    task automatic do_read(input int np, input int nbytes, input logic collide, input string tag);
        logic [7:0] exp_b [10];
        logic [7:0] got;
        int nexp = 0;
        int head0;
        int nread;
        logic full;
        if (np == 1) begin
            exp_b[0] = {status_misc, m_done};
            nexp = 1;
        end
        exp_b[nexp] = exp_cnt();
        nexp++;
        for (int k = 0; k < int'(m_len); k++) begin
            exp_b[nexp] = exp_fifo(k);
            nexp++;
        end
        nread = (nbytes < nexp) ? nbytes : nexp;
        full = (nread == nexp);
        head0 = head;
        sin = 1'b0; clks(6);
        for (int p = 0; p < np; p++) begin
            sdi = 1'b1; clks(5); sdi = 1'b0; clks(5);
        end
        for (int b = 0; b < nread; b++) begin
            for (int i = 0; i < 8; i++) begin
                got[i] = sdo;
                if (b == nread - 1 && i == 7 && !full) break;
                if (b == nread - 1 && i == 7 && collide) begin
                    sck = 1'b0;
                    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
                    drive_pkt(2'd0, 1'b1, 1'b1, 4'd0);
                    @(negedge clk);
                    pkt_valid = 1'b0; head_clr = 1'b0;
                    clks(4); sck = 1'b1; clks(6);
                end else begin
                    sck = 1'b0; clks(6); sck = 1'b1; clks(6);
                end
            end
            chk(got, exp_b[b], $sformatf("%s byte %0d (R2 R3 R5)", tag, b));
        end
        if (full) begin
            chk(8'(head - head0), 8'(collide ? 0 : int'(m_len)) , {tag, " pop count R10"});
            if (!collide) begin
                m_setup = 1'b0;
                if (np == 1) m_done = 1'b0;
            end
        end
        clks(3);
        sin = 1'b1; clks(6);
        chk({7'd0, sdo}, 8'd1, {tag, " idle sdo R1 R11"});
    endtask

    initial begin
        clks(5);
        rst_n = 1'b1;
        clks(6);
        // R1: reset state
        chk({7'd0, sdo}, 8'd1, "reset sdo R1");
        do_read(1, 2, 1'b0, "reset R1 R9");

        // R4: sdo held while select low with no strobe
        sin = 1'b0; clks(20);
        chk({7'd0, sdo}, 8'd1, "no strobe hold R4");
        sin = 1'b1; clks(6);

        // Sweep: lengths 0..9, all endpoints, both start modes, enable combinations
        for (int len = 0; len <= 9; len++) begin
            for (int ep = 0; ep < 3; ep++) begin
                int cfg = len + ep;
                ep1_en = cfg[0]; ep2_en = cfg[1];
                status_misc = 7'(len * 13 + ep);
                send_pkt(2'(ep), len[0], (ep == 0) && (len % 3 == 0), 4'(len));
                do_read(((len + ep) % 2) + 1, 99, 1'b0, "sweep R6 R7 R8 R9 R10");
                do_read(1, 2, 1'b0, "flags after read R7 R8");
            end
        end

        // R6: ignored packets leave the fields unchanged
        ep1_en = 1'b1; ep2_en = 1'b0;
        send_pkt(2'd0, 1'b0, 1'b0, 4'd3);
        send_pkt(2'd1, 1'b1, 1'b1, 4'd7);
        send_pkt(2'd3, 1'b1, 1'b0, 4'd5);
        do_read(2, 2, 1'b0, "ignored packets R6");

        // R11: early end keeps both flags
        send_pkt(2'd0, 1'b1, 1'b1, 4'd4);
        do_read(1, 3, 1'b0, "abort in fifo R11");
        do_read(1, 2, 1'b0, "flags kept after abort R11");

        // R8: a two-pulse full read keeps OUT-done, clears SETUP
        send_pkt(2'd0, 1'b0, 1'b1, 4'd2);
        do_read(2, 99, 1'b0, "two-pulse full R8");
        do_read(1, 2, 1'b0, "done kept R8 R7");

        // R12: packet accepted in the completion cycle
        send_pkt(2'd0, 1'b0, 1'b1, 4'd0);
        do_read(1, 99, 1'b1, "collision R12");
        do_read(1, 2, 1'b0, "set wins R12");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule